// File: doc/BRIEF.md
# Adaptive-Threshold Variable Node Unit

This block is the per-node variable update of a normalized min-sum LDPC decoder, for a single variable node. Each time a controller strobes `start`, the unit takes the node's channel LLR, the check-to-variable messages on its edges and the two thresholds that the controller has chosen for this node's type. It then makes one update and returns a new a-posteriori LLR, one outgoing variable-to-check message per edge and a flag that says whether the node sat the iteration out. The a-posteriori LLR from the previous update stays in the unit's own output register. It serves both as the output and as the reliability measure used for the next decision.

If the previous a-posteriori magnitude has reached the deactivation threshold, the node skips the update. It repeats its last outputs and raises `deact`. Otherwise it forms the full sum and the per-edge extrinsic sums, saturating each one, and sends a zero instead of any extrinsic message that is weaker than the zero-forcing threshold. A first-iteration strobe loads the channel LLR everywhere. A `reactivate` pulse clears the skip flag, so the next update is judged afresh against the newly raised threshold. Thresholds are computed elsewhere, and message routing and storage also belong to other blocks.

The control is a two-state machine. ST_IDLE goes to ST_DONE when `start` is sampled high and otherwise stays in ST_IDLE. ST_DONE goes back to ST_IDLE when `start` is low and stays in ST_DONE for a back-to-back strobe. `done` is high in ST_DONE.

Top module: `vnu_node`

## Requirements
- R1: When `start` is sampled with `first_iter` high, `app_llr` and every enabled edge message become the channel LLR, and `deact` becomes 0. Edge e of a bus occupies bits [e*W +: W], and bit e of `edge_en` enables it. All LLRs are two's complement with W=7 bits and 3 fractional bits (LSB = 1/8).
- R2: `done` is high in exactly the cycle after each cycle in which `start` is sampled high, and never otherwise. The new outputs are visible in that same cycle.
- R3: Outside the first iteration, the node skips the update (`deact`=1) when the magnitude of the held `app_llr` is greater than or equal to `deact_thr`, read as unsigned. It updates when the magnitude is smaller.
- R4: A skipped update leaves `app_llr` and `v2c_out` unchanged, whatever the new channel and check inputs are.
- R5: An update sets `app_llr` to the channel LLR plus the sum of all enabled check messages, and clears `deact`.
- R6: On an update, enabled edge e sends the channel LLR plus the sum of all enabled check messages other than edge e's own.
- R7: Every sum saturates to the symmetric range -63..+63 (in LSBs). The code -64 never appears on an output.
- R8: On an update, an edge message whose magnitude is below `zero_thr` (unsigned) is sent as 0. A magnitude equal to the threshold is kept.
- R9: A disabled edge's check input has no effect on any output, and that edge's outgoing message is 0.
- R10: A `reactivate` pulse with `start` low clears `deact` in the next cycle and leaves `app_llr` as it was. The following update is judged against the threshold supplied with it.
- R11: Reset clears `app_llr`, `v2c_out`, `deact` and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Update strobe; data inputs are sampled with it |
| first_iter | input | 1 | Load the channel LLR instead of updating |
| reactivate | input | 1 | Clear the skip flag |
| llr_ch | input | W | Channel LLR |
| c2v_in | input | DEG*W | Incoming check messages, edge e at [e*W +: W] |
| edge_en | input | DEG | Enable per edge port |
| deact_thr | input | W | Deactivation threshold for this node type (unsigned) |
| zero_thr | input | W | Zero-forcing threshold for this node type (unsigned) |
| app_llr | output | W | A-posteriori LLR |
| v2c_out | output | DEG*W | Outgoing messages, edge e at [e*W +: W] |
| deact | output | 1 | Node skipped its latest update |
| done | output | 1 | Outputs updated this cycle |

## Verification
The bench drives the skip decision with the held magnitude exactly equal to the threshold and then one below it. A design that compares with the wrong strictness would update when it should hold, or the reverse. One extrinsic value lands exactly on the zero-forcing threshold, which catches an off-by-one that zeroes it. Others fall just below it and must be dropped. Large same-sign inputs push both the total and the extrinsic sums past the range. A wrapping adder would flip their sign, and an asymmetric clamp would emit -64. Disabled edges carry large values that would show up in every sum if they leaked through. A reactivate pulse followed by a raised threshold checks that the skip flag does not stick.

// File: rtl/vnu_pkg.sv
package vnu_pkg;

    // Control states of the node unit.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } vnu_state_e;

endpackage

// File: rtl/vnu_sum.sv
// Saturating total and per-edge extrinsic sums of the node's inputs.
module vnu_sum #(
    parameter int W   = 7,
    parameter int DEG = 4
) (
    input  logic [W-1:0]     ch,
    input  logic [DEG*W-1:0] c2v_bus,
    input  logic [DEG-1:0]   valid,
    output logic [W-1:0]     app_sat,
    output logic [DEG*W-1:0] ext_bus
);
    // Wide enough for DEG+1 full-scale terms plus a sign.
    localparam int SW = W + $clog2(DEG + 1) + 1;
    localparam logic signed [SW-1:0] POS_LIM = SW'((2 ** (W - 1)) - 1);
    localparam logic signed [SW-1:0] NEG_LIM = -POS_LIM;

    function automatic logic [W-1:0] clamp(input logic signed [SW-1:0] v);
        if (v > POS_LIM)      return POS_LIM[W-1:0];
        else if (v < NEG_LIM) return NEG_LIM[W-1:0];
        else                  return v[W-1:0];
    endfunction

    logic signed [SW-1:0] term [DEG];
    logic signed [SW-1:0] total;

    for (genvar e = 0; e < DEG; e++) begin : g_term
        assign term[e] = valid[e] ? SW'($signed(c2v_bus[e*W +: W])) : '0;
    end

    always_comb begin
        total = SW'($signed(ch));
        for (int e = 0; e < DEG; e++) begin
            total = total + term[e];
        end
    end

    assign app_sat = clamp(total);

    // Extrinsic value = full sum minus own edge, exact before clamping.
    for (genvar e = 0; e < DEG; e++) begin : g_ext
        assign ext_bus[e*W +: W] = valid[e] ? clamp(total - term[e]) : '0;
    end

endmodule

// File: rtl/vnu_zforce.sv
// Replaces weak per-edge messages with zero.
module vnu_zforce #(
    parameter int W   = 7,
    parameter int DEG = 4
) (
    input  logic [DEG*W-1:0] msg_in,
    input  logic [W-1:0]     thr,
    output logic [DEG*W-1:0] msg_out
);
    for (genvar e = 0; e < DEG; e++) begin : g_edge
        logic [W-1:0] val;
        logic [W-1:0] mag;
        assign val = msg_in[e*W +: W];
        assign mag = val[W-1] ? W'(-val) : val;
        assign msg_out[e*W +: W] = (mag < thr) ? '0 : val;
    end

endmodule

// File: rtl/vnu_node.sv
module vnu_node
    import vnu_pkg::*;
#(
    parameter int W   = 7,
    parameter int DEG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             first_iter,
    input  logic             reactivate,
    input  logic [W-1:0]     llr_ch,
    input  logic [DEG*W-1:0] c2v_in,
    input  logic [DEG-1:0]   edge_en,
    input  logic [W-1:0]     deact_thr,
    input  logic [W-1:0]     zero_thr,
    output logic [W-1:0]     app_llr,
    output logic [DEG*W-1:0] v2c_out,
    output logic             deact,
    output logic             done
);
    localparam int BUS_W = DEG * W;

    vnu_state_e state_q, state_d;

    logic [W-1:0]     app_sum;
    logic [BUS_W-1:0] ext_raw;
    logic [BUS_W-1:0] ext_forced;
    logic [BUS_W-1:0] init_bus;
    logic [W-1:0]     app_mag;
    logic             skip;

    vnu_sum #(.W(W), .DEG(DEG)) i_sum (
        .ch      (llr_ch),
        .c2v_bus (c2v_in),
        .valid   (edge_en),
        .app_sat (app_sum),
        .ext_bus (ext_raw)
    );

    vnu_zforce #(.W(W), .DEG(DEG)) i_zf (
        .msg_in  (ext_raw),
        .thr     (zero_thr),
        .msg_out (ext_forced)
    );

    for (genvar e = 0; e < DEG; e++) begin : g_init
        assign init_bus[e*W +: W] = edge_en[e] ? llr_ch : '0;
    end

    assign app_mag = app_llr[W-1] ? W'(-app_llr) : app_llr;
    assign skip    = (app_mag >= deact_thr);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign done = (state_q == ST_DONE);

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            app_llr <= '0;
            v2c_out <= '0;
            deact   <= 1'b0;
        end else if (start) begin
            if (first_iter) begin
                app_llr <= llr_ch;
                v2c_out <= init_bus;
                deact   <= 1'b0;
            end else if (skip) begin
                deact   <= 1'b1;
            end else begin
                app_llr <= app_sum;
                v2c_out <= ext_forced;
                deact   <= 1'b0;
            end
        end else if (reactivate) begin
            deact <= 1'b0;
        end
    end

    // R2: done follows each sampled strobe, and only then.
    a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R1: the first iteration loads the channel LLR.
    a_r1_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(first_iter)) |-> (app_llr == $past(llr_ch) && !deact));

    // R4: a skipped update holds the outputs.
    a_r4_hold_when_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (done && deact) |-> ($stable(app_llr) && $stable(v2c_out)));

    // R10: reactivate clears the skip flag.
    a_r10_reactivate_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reactivate && !start) |=> !deact);

    // R7: the asymmetric code never leaves the unit.
    a_r7_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        app_llr != {1'b1, {(W-1){1'b0}}});

    for (genvar e = 0; e < DEG; e++) begin : g_chk
        logic [W-1:0] o_val;
        logic [W-1:0] o_mag;
        assign o_val = v2c_out[e*W +: W];
        assign o_mag = o_val[W-1] ? W'(-o_val) : o_val;

        // R8: surviving messages reach the zero-forcing threshold.
        a_r8_weak_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !deact && !$past(first_iter)) |-> (o_mag == '0 || o_mag >= $past(zero_thr)));

        // R9: disabled edges send nothing.
        a_r9_disabled_edge_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !deact && !$past(edge_en[e])) |-> (o_val == '0));
    end

endmodule

// File: tb/test_vnu_node.sv
`timescale 1ns/1ps
module test_vnu_node;
    localparam int W = 7;
    localparam int DEG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, first_iter = 1'b0, reactivate = 1'b0;
    logic [W-1:0] llr_ch = '0, deact_thr = '0, zero_thr = '0;
    logic [DEG*W-1:0] c2v_in = '0;
    logic [DEG-1:0] edge_en = '0;
    logic [W-1:0] app_llr;
    logic [DEG*W-1:0] v2c_out;
    logic deact, done;

    always #2 clk = ~clk;

    vnu_node #(.W(W), .DEG(DEG)) i_vnu_node (
        .clk(clk), .rst_n(rst_n), .start(start), .first_iter(first_iter),
        .reactivate(reactivate), .llr_ch(llr_ch), .c2v_in(c2v_in),
        .edge_en(edge_en), .deact_thr(deact_thr), .zero_thr(zero_thr),
        .app_llr(app_llr), .v2c_out(v2c_out), .deact(deact), .done(done)
    );

    typedef struct {
        logic [W-1:0]     app;
        logic [DEG*W-1:0] v2c;
        logic             dflag;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    int m_app = 0;
    logic [DEG*W-1:0] m_v2c = '0;

    function automatic int sat(input int v);
        if (v > 63) return 63;
        if (v < -63) return -63;
        return v;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Driver: computes the expected result, queues it, strobes start.
    task automatic do_iter(input bit first, input int ch, input int c0, input int c1,
                           input int c2, input int c3, input logic [3:0] en,
                           input int td, input int tz, input string tag);
        int c[4];
        int tot;
        exp_t x;
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
        x.tag = tag;
        if (first) begin
            x.app = W'(ch);
            x.dflag = 1'b0;
            for (int e = 0; e < DEG; e++) x.v2c[e*W +: W] = en[e] ? W'(ch) : '0;
        end else if (iabs(m_app) >= td) begin
            x.app = W'(m_app);
            x.v2c = m_v2c;
            x.dflag = 1'b1;
        end else begin
            tot = ch;
            for (int e = 0; e < DEG; e++) if (en[e]) tot += c[e];
            x.app = W'(sat(tot));
            x.dflag = 1'b0;
            for (int e = 0; e < DEG; e++) begin
                int v;
                v = en[e] ? sat(tot - c[e]) : 0;
                if (iabs(v) < tz) v = 0;
                x.v2c[e*W +: W] = W'(v);
            end
        end
        m_app = $signed(x.app);
        m_v2c = x.v2c;
        @(negedge clk);
        exp_q.push_back(x);
        first_iter = first;
        llr_ch = W'(ch);
        c2v_in = {W'(c3), W'(c2), W'(c1), W'(c0)};
        edge_en = en;
        deact_thr = W'(td);
        zero_thr = W'(tz);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1, "R2 done after start", int'(done), 1);
        @(negedge clk);
        check(done === 1'b0, "R2 single done pulse", int'(done), 0);
    endtask

    // Monitor: pops expected items as done appears.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected done", 1, 0);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(app_llr === x.app, {x.tag, " app_llr"}, $signed(app_llr), $signed(x.app));
                check(deact === x.dflag, {x.tag, " deact"}, int'(deact), int'(x.dflag));
                for (int e = 0; e < DEG; e++)
                    check(v2c_out[e*W +: W] === x.v2c[e*W +: W], $sformatf("%s v2c edge %0d", x.tag, e),
                          $signed(v2c_out[e*W +: W]), $signed(x.v2c[e*W +: W]));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(app_llr === '0 && v2c_out === '0, "R11 reset outputs", int'(app_llr), 0);
        check(deact === 1'b0 && done === 1'b0, "R11 reset flags", int'(deact) + int'(done), 0);

        do_iter(1, 10, 0, 0, 0, 0, 4'hF, 63, 0, "R1");
        do_iter(0, 10, 5, -3, 20, -8, 4'hF, 63, 4, "R5 R6 R8");
        do_iter(0, -6, 3, 2, -1, 9, 4'hF, 63, 8, "R8");
        do_iter(0, 40, 30, 30, 30, 30, 4'hF, 64, 0, "R7");
        do_iter(0, -40, -30, -30, -30, -30, 4'hF, 64, 0, "R7");
        do_iter(1, 8, 0, 0, 0, 0, 4'hF, 64, 0, "R1");
        do_iter(0, 8, 50, -2, 50, 3, 4'b1010, 64, 0, "R9");
        do_iter(0, 20, 7, 7, 7, 7, 4'hF, 9, 0, "R3 R4");

        @(negedge clk);
        reactivate = 1'b1;
        @(negedge clk);
        reactivate = 1'b0;
        check(deact === 1'b0, "R10 deact cleared", int'(deact), 0);
        check($signed(app_llr) == m_app, "R10 app kept", $signed(app_llr), m_app);

        do_iter(0, 1, 1, 1, 1, 1, 4'hF, 10, 0, "R10 R3");
        do_iter(0, 2, 0, 0, 0, 0, 4'hF, 6, 0, "R3");
        do_iter(0, 3, 4, 4, 4, 4, 4'hF, 2, 0, "R3 R4");
        do_iter(1, -63, 0, 0, 0, 0, 4'b0011, 63, 0, "R1");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
        summary();
    end

endmodule